// File: doc/BRIEF.md
# Output Fault Diagnostic Sequencer

This block supervises load diagnostics for a bridged amplifier output stage. It receives five raw comparator indications (output-to-output short, open load, short to a supply rail, over-current, over-temperature) and the decoded control fields: diagnostic start, continuous mode, fault reset and a per-fault mask. It decides when each comparator is taken into account, latches faults, and drives an active-low fault flag, an output-disable, a shutdown hold for the amplifier and a hold that tells the register front end to defer writes.

After reset a full diagnostic pass runs on its own with the amplifier held in shutdown. Afterwards, software starts passes by raising the start bit, either once or repeating on a fixed period. The load tests (rail short, output short, open load) count only inside a pass. The over-current and thermal monitors count at all times. A mask bit hides a fault from the flag but never from the protection path. Timing comes from a prescaler: one tick every `TICK_DIV` clocks, a pass of `SEQ_TICKS` ticks and a repeat period of `PERIOD_TICKS` ticks. With a 50 MHz clock, the defaults give 1 ms ticks, a 58 ms pass and a 60 ms period.

Top module: `diag_seq`

## Requirements
- R1: After reset a diagnostic pass of SEQ_TICKS*TICK_DIV clocks runs whatever diag_en is. shutdown_hold and wr_defer are high throughout that pass and never return high until the next reset. A diag_en level held during this pass is seen as a start edge once the pass ends.
- R2: fault_clr sampled high during the power-up pass ends it at that clock edge.
- R3: A rising edge of diag_en starts a pass. With diag_cont low at that edge, exactly one pass runs. diag_en held high starts nothing more, and a new pass needs diag_en low and then high again.
- R4: With diag_cont high at the start edge, a pass starts every PERIOD_TICKS ticks, start to start. The load tests are live for the first SEQ_TICKS ticks of each period and are ignored in the gap.
- R5: Continuous repetition stops when the fault flag is latched, when fault_clr rises, or when diag_cont is cleared.
- R6: Bits 0 (output-to-output short), 1 (open load) and 2 (rail short) of raw_flt are acted on only inside a pass. Outside a pass they have no effect on any output.
- R7: Bits 3 (over-current) and 4 (thermal) of raw_flt are acted on at every clock, inside or outside a pass.
- R8: An acted-on fault whose mask bit is 0 drives fault_n low and out_disable high at the next edge. Both stay that way after the input clears, until fault_clr rises.
- R9: An acted-on fault whose mask bit (same bit position as raw_flt) is 1 leaves fault_n high but still drives out_disable high.
- R10: A rising edge of fault_clr clears fault_n to 1, out_disable to 0 and flt_src to 0 at the next edge. The clear wins over a fault seen in the same cycle.
- R11: flt_src captures the set of unmasked acted-on faults at the edge where the flag latches. It holds that value while the flag stays low and reads 0 while fault_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| diag_en | input | 1 | Diagnostic start; rising edge starts a pass |
| diag_cont | input | 1 | Continuous mode select, sampled at the start edge |
| fault_clr | input | 1 | Fault reset; rising edge clears latches, high ends power-up pass |
| mask | input | 5 | Per-fault flag mask, same bit order as raw_flt |
| raw_flt | input | 5 | Raw comparators: 0 out short, 1 open, 2 rail, 3 over-current, 4 thermal |
| fault_n | output | 1 | Latched fault flag, active low |
| out_disable | output | 1 | Output stage disable from latched protection |
| shutdown_hold | output | 1 | Holds amplifier in shutdown during power-up pass |
| wr_defer | output | 1 | Tells the register front end to defer writes |
| flt_src | output | 5 | Unmasked faults that caused the latch |

## Verification
The comparators are driven in distinct groupings. Load faults are applied inside and outside a pass, which separates the pass window from idle. Thermal and over-current are applied while idle, which shows they are always live. Masked and unmasked copies of the same fault show that the flag path and the protection path are separate. In continuous mode a rail short is placed first in the gap and then inside the next period's window, which checks the period arithmetic. The same late injection after a latch, after a reset edge and after diag_cont is cleared shows each way repetition stops. Holding diag_en high and then re-arming it separates edge triggering from level triggering.

// File: rtl/diag_seq.sv
module diag_seq #(
  parameter int TICK_DIV     = 50000,
  parameter int SEQ_TICKS    = 58,
  parameter int PERIOD_TICKS = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       diag_en,
  input  logic       diag_cont,
  input  logic       fault_clr,
  input  logic [4:0] mask,
  input  logic [4:0] raw_flt,
  output logic       fault_n,
  output logic       out_disable,
  output logic       shutdown_hold,
  output logic       wr_defer,
  output logic [4:0] flt_src
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TW = $clog2(PERIOD_TICKS + 1);
  localparam logic [4:0]    SEQ_ONLY = 5'b00111;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [TW-1:0] SEQ_LEN  = TW'(SEQ_TICKS);
  localparam logic [TW-1:0] SEQ_LAST = TW'(SEQ_TICKS - 1);
  localparam logic [TW-1:0] PER_LAST = TW'(PERIOD_TICKS - 1);

  typedef enum logic [1:0] {S_PWRUP, S_IDLE, S_RUN} st_t;

  st_t           st;
  logic [PW-1:0] pre;
  logic [TW-1:0] tcnt;
  logic          en_q, clr_q, cont_q, flt_q, prot_q;
  logic [4:0]    src_q;

  logic       en_rise, clr_rise, tick, win;
  logic [4:0] det, hit;

  assign en_rise  = diag_en & ~en_q;
  assign clr_rise = fault_clr & ~clr_q;
  assign tick     = (pre == PRE_LAST);
  assign win      = (st == S_PWRUP) || (st == S_RUN && tcnt < SEQ_LEN);
  assign det      = raw_flt & (win ? 5'b11111 : ~SEQ_ONLY);
  assign hit      = det & ~mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_PWRUP;
      pre    <= '0;
      tcnt   <= '0;
      cont_q <= 1'b0;
      en_q   <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= fault_clr;
      en_q  <= (st == S_PWRUP) ? 1'b0 : diag_en;
      pre   <= tick ? '0 : pre + 1'b1;
      if (tick) tcnt <= tcnt + 1'b1;
      case (st)
        S_PWRUP:
          if (fault_clr || (tick && tcnt == SEQ_LAST)) st <= S_IDLE;
        S_IDLE:
          if (en_rise) begin
            st     <= S_RUN;
            cont_q <= diag_cont;
            pre    <= '0;
            tcnt   <= '0;
          end
        S_RUN:
          if (flt_q || clr_rise || (cont_q && !diag_cont)) begin
            st <= S_IDLE;
          end else if (tick) begin
            if (cont_q) begin
              if (tcnt == PER_LAST) tcnt <= '0;
            end else if (tcnt == SEQ_LAST) begin
              st <= S_IDLE;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q  <= 1'b0;
      prot_q <= 1'b0;
      src_q  <= '0;
    end else if (clr_rise) begin
      flt_q  <= 1'b0;
      prot_q <= 1'b0;
      src_q  <= '0;
    end else begin
      if (|det) prot_q <= 1'b1;
      if (|hit) flt_q  <= 1'b1;
      if (!flt_q && |hit) src_q <= hit;
    end
  end

  assign fault_n       = ~flt_q;
  assign out_disable   = prot_q;
  assign shutdown_hold = (st == S_PWRUP);
  assign wr_defer      = shutdown_hold;
  assign flt_src       = src_q;

endmodule

// File: rtl/diag_seq_chk.sv
module diag_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fault_clr,
  input logic [4:0] mask,
  input logic [4:0] raw_flt,
  input logic       fault_n,
  input logic       out_disable,
  input logic       shutdown_hold,
  input logic [4:0] flt_src
);

  AST_HOLD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown_hold |=> !shutdown_hold); // R1

  AST_THERMAL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_flt[4] && !mask[4] && !$rose(fault_clr)) |=> !fault_n); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !$rose(fault_clr)) |=> !fault_n); // R8

  AST_FLAG_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> out_disable); // R8

  AST_MASK_KEEPS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_flt[3] && !$rose(fault_clr)) |=> out_disable); // R9

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_clr) |=> (fault_n && !out_disable && flt_src == 5'b0)); // R10

  AST_SRC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fault_n |-> (flt_src == 5'b0)); // R11

endmodule

bind diag_seq diag_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fault_clr(fault_clr), .mask(mask),
  .raw_flt(raw_flt), .fault_n(fault_n), .out_disable(out_disable),
  .shutdown_hold(shutdown_hold), .flt_src(flt_src)
);

// File: tb/diag_seq_tb.sv
module diag_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       diag_en = 1'b0, diag_cont = 1'b0, fault_clr = 1'b0;
  logic [4:0] mask = '0, raw_flt = '0;
  logic       fault_n, out_disable, shutdown_hold, wr_defer;
  logic [4:0] flt_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic       fn;
    logic       dis;
    logic       hold;
    logic [4:0] src;
  } exp_t;

  exp_t sb_q[$];
  event sb_ev;

  localparam logic [4:0] F_SHORT = 5'b00001, F_OPEN = 5'b00010, F_RAIL = 5'b00100,
                         F_OC = 5'b01000, F_TH = 5'b10000;

  always #10 clk = ~clk;

  diag_seq #(.TICK_DIV(4), .SEQ_TICKS(5), .PERIOD_TICKS(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .diag_en(diag_en), .diag_cont(diag_cont),
    .fault_clr(fault_clr), .mask(mask), .raw_flt(raw_flt), .fault_n(fault_n),
    .out_disable(out_disable), .shutdown_hold(shutdown_hold), .wr_defer(wr_defer),
    .flt_src(flt_src)
  );

  initial begin : monitor
    exp_t it;
    forever begin
      @(sb_ev);
      while (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        checks++;
        if (fault_n !== it.fn || out_disable !== it.dis || shutdown_hold !== it.hold ||
            wr_defer !== it.hold || flt_src !== it.src) begin
          errors++;
          $display("FAIL %s: fault_n=%0b exp %0b, out_disable=%0b exp %0b, hold=%0b/%0b exp %0b, src=%05b exp %05b",
                   it.tag, fault_n, it.fn, out_disable, it.dis, shutdown_hold, wr_defer,
                   it.hold, flt_src, it.src);
        end
      end
    end
  end

  task automatic go(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic fn, input logic dis,
                            input logic hold, input logic [4:0] src);
    exp_t it;
    it.tag = tag; it.fn = fn; it.dis = dis; it.hold = hold; it.src = src;
    sb_q.push_back(it);
    -> sb_ev;
    #1;
  endtask

  task automatic do_reset();
    diag_en = 0; diag_cont = 0; fault_clr = 0; mask = '0; raw_flt = '0;
    rst_n = 0;
    go(3);
    rst_n = 1;
  endtask

  task automatic pulse_clear();
    fault_clr = 1;
    go(1);
    fault_clr = 0;
    go(1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    go(1);
    do_reset();
    go(2);
    expect_out("R1 reset state in power-up pass", 1, 0, 1, 5'b0);
    raw_flt = F_RAIL;
    go(2);
    expect_out("R6 rail short caught in power-up pass", 0, 1, 1, F_RAIL);
    raw_flt = 0;
    go(2);
    expect_out("R8 flag sticky after input clears", 0, 1, 1, F_RAIL);
    go(25);
    expect_out("R1 hold released after pass", 0, 1, 0, F_RAIL);
    fault_clr = 1;
    go(1);
    expect_out("R10 clear on fault_clr rise", 1, 0, 0, 5'b0);
    fault_clr = 0;
    go(1);

    do_reset();
    go(3);
    expect_out("R2 still in power-up pass", 1, 0, 1, 5'b0);
    fault_clr = 1;
    go(1);
    expect_out("R2 power-up pass ended by fault_clr", 1, 0, 0, 5'b0);
    fault_clr = 0;
    go(1);

    raw_flt = F_SHORT | F_OPEN | F_RAIL;
    go(3);
    expect_out("R6 load faults ignored while idle", 1, 0, 0, 5'b0);
    raw_flt = F_OC;
    go(1);
    expect_out("R7 over-current live while idle", 0, 1, 0, F_OC);
    raw_flt = 0;
    pulse_clear();
    raw_flt = F_TH;
    go(1);
    expect_out("R7 thermal live while idle", 0, 1, 0, F_TH);
    raw_flt = 0;
    pulse_clear();
    expect_out("R10 cleared after thermal", 1, 0, 0, 5'b0);

    mask = F_OC;
    raw_flt = F_OC;
    go(2);
    expect_out("R9 masked over-current still disables", 1, 1, 0, 5'b0);
    raw_flt = 0;
    pulse_clear();
    mask = 0;

    diag_cont = 0;
    diag_en = 1;
    go(5);
    raw_flt = F_OPEN;
    go(2);
    expect_out("R3 one-shot pass runs open-load test", 0, 1, 0, F_OPEN);
    raw_flt = 0;
    go(30);
    pulse_clear();
    raw_flt = F_OPEN;
    go(3);
    expect_out("R3 no new pass while enable held", 1, 0, 0, 5'b0);
    raw_flt = 0;
    diag_en = 0;
    go(2);
    diag_en = 1;
    go(4);
    raw_flt = F_SHORT;
    go(2);
    expect_out("R3 re-armed pass runs output-short test", 0, 1, 0, F_SHORT);
    raw_flt = 0;
    go(30);
    pulse_clear();
    diag_en = 0;
    go(2);

    diag_en = 1;
    go(30);
    raw_flt = F_RAIL;
    go(3);
    expect_out("R6 rail ignored after one-shot pass ends", 1, 0, 0, 5'b0);
    raw_flt = 0;
    diag_en = 0;
    go(1);

    mask = F_OPEN;
    diag_en = 1;
    go(4);
    raw_flt = F_OPEN;
    go(2);
    expect_out("R9 masked open load in pass disables only", 1, 1, 0, 5'b0);
    raw_flt = 0;
    go(30);
    pulse_clear();
    mask = 0;
    diag_en = 0;
    go(1);

    diag_cont = 1;
    diag_en = 1;
    go(26);
    raw_flt = F_RAIL;
    go(10);
    expect_out("R4 rail ignored in continuous gap", 1, 0, 0, 5'b0);
    raw_flt = 0;
    go(14);
    raw_flt = F_RAIL;
    go(2);
    expect_out("R4 next period retests rail", 0, 1, 0, F_RAIL);
    raw_flt = 0;
    go(30);
    pulse_clear();
    go(13);
    raw_flt = F_RAIL;
    go(3);
    expect_out("R5 repetition stopped by latched flag", 1, 0, 0, 5'b0);
    raw_flt = 0;

    diag_en = 0;
    go(2);
    diag_en = 1;
    go(24);
    diag_cont = 0;
    go(26);
    raw_flt = F_RAIL;
    go(3);
    expect_out("R5 repetition stopped by clearing continuous", 1, 0, 0, 5'b0);
    raw_flt = 0;
    diag_en = 0;
    diag_cont = 1;
    go(2);
    diag_en = 1;
    go(24);
    pulse_clear();
    go(24);
    raw_flt = F_RAIL;
    go(3);
    expect_out("R5 repetition stopped by fault reset", 1, 0, 0, 5'b0);
    raw_flt = 0;
    diag_en = 0;
    diag_cont = 0;
    go(1);

    raw_flt = F_OC | F_TH;
    go(1);
    expect_out("R11 source records both faults", 0, 1, 0, F_OC | F_TH);
    raw_flt = 0;
    go(3);
    expect_out("R11 source held while latched", 0, 1, 0, F_OC | F_TH);
    pulse_clear();
    mask = F_TH;
    raw_flt = F_OC | F_TH;
    go(1);
    expect_out("R11 source omits masked fault", 0, 1, 0, F_OC);
    raw_flt = 0;
    mask = 0;
    pulse_clear();
    expect_out("R10 final clear", 1, 0, 0, 5'b0);

    go(2);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule